// File: doc/BRIEF.md
# Banked Thermal Configuration Register Interface

This block is the register window between a host processor and a thermal management unit. The host reaches it through a small memory-mapped bus: a 3-bit address, 8-bit write and read data, a write/read select and an enable. Behind the bus sit programmable limits for each temperature sensor, a pair of limits on the temperature spread between sensors, fan stage settings, two mask registers and three configuration registers. The register contents leave the block as plain outputs toward the comparison logic and the fan drivers.

Only eight addresses exist, so the per-sensor registers are banked. A field in the bank-control register picks one sensor, and the high-limit, low-limit and fan-stage addresses then reach that sensor's copy. A second field picks which of four registers sits behind the shared mask address. A third field picks what the status address returns: a live sensor temperature, the spread temperature, or the pending interrupt type. Reading the interrupt type sends a one-cycle clear pulse toward the watchdog so the service routine acknowledges the event with that single read.

Top module: `thermRegIf`

## Requirements
- R1: While reset is low and right after it, every high limit reads 8'hFF, every low limit 8'h00, the spread upper limit 8'hFF, the spread lower limit 8'h00, both masks, both auxiliary configuration registers, every fan stage, the bank-control register and regRdata are 8'h00, and intClr is 0.
- R2: Address 0 is the bank-control register, read and written as a full byte: bits [1:0] select the sensor, bits [3:2] select the register behind address 5, bits [5:4] select the source of address 7.
- R3: A write to address 1 (high limit) or address 2 (low limit) changes only the copy of the selected sensor; a read returns the selected sensor's copy; sensor i's limits appear on hiThresh/loThresh bits [8i+7:8i].
- R4: Address 3 holds the spread upper limit and address 4 the spread lower limit; both are readable and drive offUpper and offLower.
- R5: Address 5 reaches the interrupt mask when bits [3:2] are 0, the spread mask when 1, auxiliary configuration A when 2 and auxiliary configuration B when 3.
- R6: Address 6 reaches the fan stage of the selected sensor for selections 0, 1 and 2 (fan j on fanStage bits [8j+7:8j]); with selection 3 a write changes nothing and a read returns 8'h00.
- R7: A read of address 7 returns the live temperature of the selected sensor when bits [5:4] are 0, offsetTemp when 1, intType when 2 and 8'h00 when 3; a write to address 7 changes nothing.
- R8: intClr is high in exactly the cycles that follow a read of address 7 with bits [5:4] equal to 2; no other access raises it.
- R9: Read data is registered: it appears after the clock edge that samples the read and holds until the next read; a write updates the register outputs at the edge that samples it.
- R10: With regEn low, neither a write nor a read has any effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regEn | input | 1 | Access enable |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Registered read data |
| tempIn | input | 32 | Live temperatures, sensor i on bits [8i+7:8i] |
| offsetTemp | input | 8 | Current spread temperature |
| intType | input | 8 | Pending interrupt type code |
| intClr | output | 1 | One-cycle clear after an interrupt type read |
| hiThresh | output | 32 | High limits, sensor i on bits [8i+7:8i] |
| loThresh | output | 32 | Low limits, sensor i on bits [8i+7:8i] |
| offUpper | output | 8 | Spread upper limit |
| offLower | output | 8 | Spread lower limit |
| intMask | output | 8 | Interrupt enable mask |
| offMask | output | 8 | Sensors included in spread monitoring |
| auxCfgA | output | 8 | Auxiliary configuration A |
| auxCfgB | output | 8 | Auxiliary configuration B |
| fanStage | output | 24 | Fan stages, fan j on bits [8j+7:8j] |

## Verification
Every result of this block is due one clock edge after the access that causes it: register outputs change at the edge that samples a write, and regRdata with its intClr pulse change at the edge that samples a read. The bench drives each access on a falling edge so it is sampled at the next rising edge, and samples results on the falling edge after that. Each read pushes its expected data and clear value into a queue; a monitor that noted a read on the rising edge pops and compares on the following falling edge, and in all other cycles confirms intClr stays low. Register outputs are compared against a bench model on the falling edge after each write.

// File: rtl/thermRegPkg.sv
package thermRegPkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 2;   // sensor select field width in the bank-control register

  // address map
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI     = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO     = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_OFF_UP = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_OFF_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SUB    = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_FAN    = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd7;

  // field positions in the bank-control register
  localparam int SEL_LSB = 0;
  localparam int SUB_LSB = 2;
  localparam int SRC_LSB = 4;

  // register behind ADDR_SUB
  localparam logic [1:0] SUB_INT_MASK = 2'd0;
  localparam logic [1:0] SUB_OFF_MASK = 2'd1;
  localparam logic [1:0] SUB_AUX_A    = 2'd2;
  localparam logic [1:0] SUB_AUX_B    = 2'd3;

  // source behind ADDR_STAT
  localparam logic [1:0] SRC_TEMP = 2'd0;
  localparam logic [1:0] SRC_OFFS = 2'd1;
  localparam logic [1:0] SRC_INT  = 2'd2;

  typedef struct packed {
    logic              wrCfg;
    logic              wrHi;
    logic              wrLo;
    logic              wrOffUp;
    logic              wrOffLo;
    logic              wrSub;
    logic              wrFan;
    logic              rdStb;
    logic [ADDR_W-1:0] rdAddr;
  } regStrobe_t;
endpackage

// File: rtl/thermRegCtrl.sv
module thermRegCtrl
  import thermRegPkg::*;
(
  input  logic              regEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  logic wrAcc;
  assign wrAcc = regEn & regWr;

  always_comb begin
    strobe         = '0;
    strobe.rdStb   = regEn & ~regWr;
    strobe.rdAddr  = regAddr;
    strobe.wrCfg   = wrAcc && (regAddr == ADDR_CFG);
    strobe.wrHi    = wrAcc && (regAddr == ADDR_HI);
    strobe.wrLo    = wrAcc && (regAddr == ADDR_LO);
    strobe.wrOffUp = wrAcc && (regAddr == ADDR_OFF_UP);
    strobe.wrOffLo = wrAcc && (regAddr == ADDR_OFF_LO);
    strobe.wrSub   = wrAcc && (regAddr == ADDR_SUB);
    strobe.wrFan   = wrAcc && (regAddr == ADDR_FAN);
    // ADDR_STAT is read-only: no write strobe exists for it
  end
endmodule

// File: rtl/thermRegDatapath.sv
module thermRegDatapath
  import thermRegPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_SENSORS = 4,   // at most 2**SEL_W
  parameter int NUM_FANS    = 3    // at most NUM_SENSORS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             regWdata,
  input  logic [NUM_SENSORS*DATA_W-1:0] tempIn,
  input  logic [DATA_W-1:0]             offsetTemp,
  input  logic [DATA_W-1:0]             intType,
  output logic [DATA_W-1:0]             regRdata,
  output logic                          intClr,
  output logic [NUM_SENSORS*DATA_W-1:0] hiThresh,
  output logic [NUM_SENSORS*DATA_W-1:0] loThresh,
  output logic [DATA_W-1:0]             offUpper,
  output logic [DATA_W-1:0]             offLower,
  output logic [DATA_W-1:0]             intMask,
  output logic [DATA_W-1:0]             offMask,
  output logic [DATA_W-1:0]             auxCfgA,
  output logic [DATA_W-1:0]             auxCfgB,
  output logic [NUM_FANS*DATA_W-1:0]    fanStage
);
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] hiReg  [NUM_SENSORS];
  logic [DATA_W-1:0] loReg  [NUM_SENSORS];
  logic [DATA_W-1:0] fanReg [NUM_FANS];
  logic [SEL_W-1:0]  sensorSel;
  logic [1:0]        subSel;
  logic [1:0]        srcSel;
  logic [DATA_W-1:0] rdNext;

  assign sensorSel = cfgReg[SEL_LSB +: SEL_W];
  assign subSel    = cfgReg[SUB_LSB +: 2];
  assign srcSel    = cfgReg[SRC_LSB +: 2];

  // unbanked registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      offUpper <= '1;
      offLower <= '0;
      intMask  <= '0;
      offMask  <= '0;
      auxCfgA  <= '0;
      auxCfgB  <= '0;
    end else begin
      if (strobe.wrCfg)   cfgReg   <= regWdata;
      if (strobe.wrOffUp) offUpper <= regWdata;
      if (strobe.wrOffLo) offLower <= regWdata;
      if (strobe.wrSub) begin
        case (subSel)
          SUB_INT_MASK: intMask <= regWdata;
          SUB_OFF_MASK: offMask <= regWdata;
          SUB_AUX_A:    auxCfgA <= regWdata;
          default:      auxCfgB <= regWdata;
        endcase
      end
    end
  end

  // per-sensor limit banks
  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_sensor
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiReg[g] <= '1;
        loReg[g] <= '0;
      end else begin
        if (strobe.wrHi && sensorSel == SEL_W'(g)) hiReg[g] <= regWdata;
        if (strobe.wrLo && sensorSel == SEL_W'(g)) loReg[g] <= regWdata;
      end
    end
    assign hiThresh[g*DATA_W +: DATA_W] = hiReg[g];
    assign loThresh[g*DATA_W +: DATA_W] = loReg[g];
  end

  // fan stage bank; selections without a fan reach nothing
  for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      fanReg[f] <= '0;
      else if (strobe.wrFan && sensorSel == SEL_W'(f)) fanReg[f] <= regWdata;
    end
    assign fanStage[f*DATA_W +: DATA_W] = fanReg[f];
  end

  // read source selection
  always_comb begin
    rdNext = '0;
    case (strobe.rdAddr)
      ADDR_CFG:    rdNext = cfgReg;
      ADDR_HI:     for (int i = 0; i < NUM_SENSORS; i++) if (sensorSel == SEL_W'(i)) rdNext = hiReg[i];
      ADDR_LO:     for (int i = 0; i < NUM_SENSORS; i++) if (sensorSel == SEL_W'(i)) rdNext = loReg[i];
      ADDR_OFF_UP: rdNext = offUpper;
      ADDR_OFF_LO: rdNext = offLower;
      ADDR_SUB: begin
        case (subSel)
          SUB_INT_MASK: rdNext = intMask;
          SUB_OFF_MASK: rdNext = offMask;
          SUB_AUX_A:    rdNext = auxCfgA;
          default:      rdNext = auxCfgB;
        endcase
      end
      ADDR_FAN:    for (int i = 0; i < NUM_FANS; i++) if (sensorSel == SEL_W'(i)) rdNext = fanReg[i];
      default: begin
        case (srcSel)
          SRC_TEMP: for (int i = 0; i < NUM_SENSORS; i++)
                      if (sensorSel == SEL_W'(i)) rdNext = tempIn[i*DATA_W +: DATA_W];
          SRC_OFFS: rdNext = offsetTemp;
          SRC_INT:  rdNext = intType;
          default:  rdNext = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
      intClr   <= 1'b0;
    end else begin
      if (strobe.rdStb) regRdata <= rdNext;
      intClr <= strobe.rdStb && (strobe.rdAddr == ADDR_STAT) && (srcSel == SRC_INT);
    end
  end
endmodule

// File: rtl/thermRegIf.sv
module thermRegIf
  import thermRegPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_SENSORS = 4,
  parameter int NUM_FANS    = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regEn,
  input  logic                          regWr,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic [NUM_SENSORS*DATA_W-1:0] tempIn,
  input  logic [DATA_W-1:0]             offsetTemp,
  input  logic [DATA_W-1:0]             intType,
  output logic                          intClr,
  output logic [NUM_SENSORS*DATA_W-1:0] hiThresh,
  output logic [NUM_SENSORS*DATA_W-1:0] loThresh,
  output logic [DATA_W-1:0]             offUpper,
  output logic [DATA_W-1:0]             offLower,
  output logic [DATA_W-1:0]             intMask,
  output logic [DATA_W-1:0]             offMask,
  output logic [DATA_W-1:0]             auxCfgA,
  output logic [DATA_W-1:0]             auxCfgB,
  output logic [NUM_FANS*DATA_W-1:0]    fanStage
);
  regStrobe_t strobe;

  thermRegCtrl ctrl_i (
    .regEn   (regEn),
    .regWr   (regWr),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  thermRegDatapath #(
    .DATA_W      (DATA_W),
    .NUM_SENSORS (NUM_SENSORS),
    .NUM_FANS    (NUM_FANS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWdata   (regWdata),
    .tempIn     (tempIn),
    .offsetTemp (offsetTemp),
    .intType    (intType),
    .regRdata   (regRdata),
    .intClr     (intClr),
    .hiThresh   (hiThresh),
    .loThresh   (loThresh),
    .offUpper   (offUpper),
    .offLower   (offLower),
    .intMask    (intMask),
    .offMask    (offMask),
    .auxCfgA    (auxCfgA),
    .auxCfgB    (auxCfgB),
    .fanStage   (fanStage)
  );
endmodule

// File: rtl/thermRegChk.sv
module thermRegChk #(
  parameter int DATA_W      = 8,
  parameter int NUM_SENSORS = 4,
  parameter int NUM_FANS    = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regEn,
  input logic                          regWr,
  input logic [2:0]                    regAddr,
  input logic [DATA_W-1:0]             regRdata,
  input logic                          intClr,
  input logic [NUM_SENSORS*DATA_W-1:0] hiThresh,
  input logic [NUM_SENSORS*DATA_W-1:0] loThresh,
  input logic [DATA_W-1:0]             offUpper,
  input logic [DATA_W-1:0]             offLower,
  input logic [NUM_FANS*DATA_W-1:0]    fanStage
);
  // R8: the clear pulse only ever follows a read of the status address
  a_r8_clr_after_status_read: assert property (@(posedge clk) disable iff (!rstN)
    intClr |-> $past(regEn && !regWr && regAddr == 3'd7));

  // R9 / R10: read data moves only after an enabled read
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && !regWr) |-> $stable(regRdata));

  // R3: limit banks move only after an enabled write to their address
  a_r3_hi_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && regWr && regAddr == 3'd1) |-> $stable(hiThresh));
  a_r3_lo_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && regWr && regAddr == 3'd2) |-> $stable(loThresh));

  // R4: spread limits move only after writes to their addresses
  a_r4_up_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && regWr && regAddr == 3'd3) |-> $stable(offUpper));
  a_r4_low_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && regWr && regAddr == 3'd4) |-> $stable(offLower));

  // R6: fan stages move only after writes to the fan address
  a_r6_fan_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && regWr && regAddr == 3'd6) |-> $stable(fanStage));
endmodule

bind thermRegIf thermRegChk #(
  .DATA_W      (DATA_W),
  .NUM_SENSORS (NUM_SENSORS),
  .NUM_FANS    (NUM_FANS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regEn    (regEn),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .intClr   (intClr),
  .hiThresh (hiThresh),
  .loThresh (loThresh),
  .offUpper (offUpper),
  .offLower (offLower),
  .fanStage (fanStage)
);

// File: tb/thermRegIf_tb_top.sv
`timescale 1ns/1ps
module thermRegIf_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic [31:0] tempIn = 32'h4433_2211;
  logic [7:0]  offsetTemp = 8'h0C;
  logic [7:0]  intType = 8'h05;
  logic        intClr;
  logic [31:0] hiThresh, loThresh;
  logic [7:0]  offUpper, offLower, intMask, offMask, auxCfgA, auxCfgB;
  logic [23:0] fanStage;

  always #2.5 clk = ~clk;

  thermRegIf dut_i (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tempIn(tempIn),
    .offsetTemp(offsetTemp), .intType(intType), .intClr(intClr),
    .hiThresh(hiThresh), .loThresh(loThresh), .offUpper(offUpper),
    .offLower(offLower), .intMask(intMask), .offMask(offMask),
    .auxCfgA(auxCfgA), .auxCfgB(auxCfgB), .fanStage(fanStage)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the register file
  logic [7:0] mCfg, mOffU, mOffL, mIM, mOM, mA, mB;
  logic [7:0] mHi [4];
  logic [7:0] mLo [4];
  logic [7:0] mFan [3];
  logic [7:0] lastRd;

  // scoreboard queues
  logic [7:0] expD [$];
  logic       expC [$];
  string      expT [$];
  logic       sawRead = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mCfg;
      3'd1: return mHi[mCfg[1:0]];
      3'd2: return mLo[mCfg[1:0]];
      3'd3: return mOffU;
      3'd4: return mOffL;
      3'd5: case (mCfg[3:2]) 2'd0: return mIM; 2'd1: return mOM; 2'd2: return mA; default: return mB; endcase
      3'd6: return (mCfg[1:0] < 2'd3) ? mFan[mCfg[1:0]] : 8'h00;
      default: case (mCfg[5:4])
        2'd0: return tempIn[8*mCfg[1:0] +: 8];
        2'd1: return offsetTemp;
        2'd2: return intType;
        default: return 8'h00;
      endcase
    endcase
  endfunction

  // driver: writes update the model; caller is at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regEn = 1; regWr = 1; regAddr = a; regWdata = d;
    case (a)
      3'd0: mCfg = d;
      3'd1: mHi[mCfg[1:0]] = d;
      3'd2: mLo[mCfg[1:0]] = d;
      3'd3: mOffU = d;
      3'd4: mOffL = d;
      3'd5: case (mCfg[3:2]) 2'd0: mIM = d; 2'd1: mOM = d; 2'd2: mA = d; default: mB = d; endcase
      3'd6: if (mCfg[1:0] < 2'd3) mFan[mCfg[1:0]] = d;
      default: ;
    endcase
    @(negedge clk);
    regEn = 0; regWr = 0;
  endtask

  // driver: reads push the expected result to the scoreboard
  task automatic rd(input logic [2:0] a, input string tag);
    expD.push_back(modelRead(a));
    expC.push_back(a == 3'd7 && mCfg[5:4] == 2'd2);
    expT.push_back(tag);
    lastRd = modelRead(a);
    regEn = 1; regWr = 0; regAddr = a;
    @(negedge clk);
    regEn = 0;
  endtask

  task automatic chkOuts(input string tag);
    chk({tag, " hi"},  hiThresh, {mHi[3], mHi[2], mHi[1], mHi[0]});
    chk({tag, " lo"},  loThresh, {mLo[3], mLo[2], mLo[1], mLo[0]});
    chk({tag, " off"}, {offUpper, offLower}, {mOffU, mOffL});
    chk({tag, " msk"}, {intMask, offMask, auxCfgA, auxCfgB}, {mIM, mOM, mA, mB});
    chk({tag, " fan"}, fanStage, {mFan[2], mFan[1], mFan[0]});
  endtask

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) sawRead <= rstN && regEn && !regWr;

  always @(negedge clk) begin
    if (sawRead) begin
      if (expD.size() == 0) begin
        chk("R9 unexpected read result", 32'h1, 32'h0);
      end else begin
        automatic string t = expT.pop_front();
        chk(t, regRdata, expD.pop_front());
        chk({t, " R8 clear"}, intClr, expC.pop_front());
      end
    end else if (rstN) begin
      chk("R8 no clear without status read", intClr, 1'b0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mCfg = 0; mOffU = 8'hFF; mOffL = 0; mIM = 0; mOM = 0; mA = 0; mB = 0;
    for (int i = 0; i < 4; i++) begin mHi[i] = 8'hFF; mLo[i] = 8'h00; end
    for (int i = 0; i < 3; i++) mFan[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: values while in reset
    chkOuts("R1 in reset");
    chk("R1 rdata in reset", {regRdata, 7'd0, intClr}, 16'h0);
    rstN = 1;
    @(negedge clk);
    chkOuts("R1 after reset");
    // R1 / R2: reset read-back of every address
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset read");

    // R2: full byte readback of the bank-control register
    wr(3'd0, 8'hC3); rd(3'd0, "R2 cfg readback");

    // R3: banked limits
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 8'(s));
      wr(3'd1, 8'h80 + 8'(s));
      wr(3'd2, 8'h10 + 8'(s));
      chkOuts("R3 bank write");
    end
    for (int s = 3; s >= 0; s--) begin
      wr(3'd0, 8'(s)); rd(3'd1, "R3 hi read"); rd(3'd2, "R3 lo read");
    end

    // R4: spread limits
    wr(3'd3, 8'h3C); wr(3'd4, 8'h05);
    chkOuts("R4 spread write");
    rd(3'd3, "R4 up read"); rd(3'd4, "R4 low read");

    // R5: sub-selected registers
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 8'(k << 2)); wr(3'd5, 8'hA0 + 8'(k));
    end
    chkOuts("R5 sub write");
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 8'(k << 2)); rd(3'd5, "R5 sub read");
    end

    // R6: fan bank, selection 3 has no fan
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 8'(s)); wr(3'd6, 8'h60 + 8'(s));
    end
    chkOuts("R6 fan write with empty bank");
    rd(3'd6, "R6 empty bank read");
    wr(3'd0, 8'd1); rd(3'd6, "R6 fan1 read");

    // R7: status sources; R8 clear pulses incl. back-to-back
    tempIn = 32'h7F6E_5D4C; offsetTemp = 8'h21; intType = 8'h09;
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 8'(s)); rd(3'd7, "R7 live temp");
    end
    wr(3'd0, 8'h10); rd(3'd7, "R7 spread temp");
    wr(3'd0, 8'h20); rd(3'd7, "R8 int type"); rd(3'd7, "R8 int type again");
    wr(3'd0, 8'h30); rd(3'd7, "R7 reserved source");
    wr(3'd7, 8'h99);
    chkOuts("R7 status write ignored");
    rd(3'd0, "R7 cfg kept after status write");

    // R10: disabled accesses have no effect
    regEn = 0; regWr = 1; regAddr = 3'd1; regWdata = 8'h55;
    @(negedge clk);
    regWr = 0; regAddr = 3'd7;
    @(negedge clk);
    chkOuts("R10 disabled write");
    chk("R10 rdata held", regRdata, lastRd);

    // R9: write right after a read leaves read data held
    wr(3'd0, 8'h02); rd(3'd1, "R9 read"); wr(3'd1, 8'hEE);
    chk("R9 rdata held over write", regRdata, lastRd);
    chkOuts("R9 write visible");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", expD.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule